// File: doc/BRIEF.md
# Programmable Interrupt Priority Resolver

This block picks the winning interrupt source for each of two interrupt classes, normal (IRQ) and fast (FIQ). Software programs a table of 40 priority slots, and each slot names one source. The block searches that table against two inputs. The first is the vector of sources that are both pending and enabled. The second is the steering vector that assigns each source to IRQ or FIQ. The block then packs both winners into one 32-bit status word.

The slot table is written and read through a simple byte-addressed register port. The status word is visible on its own output and is also readable at a fixed offset of that port. The search is registered, so the status word follows the inputs with one cycle of latency. Masking of pending sources and generation of the steering vector are done outside this block.

Top module: `prio_resolver`

## Requirements
- R1: After reset every slot reads 0 (invalid) and the status word is 0x003F003F.
- R2: A slot write stores only bit 31 (valid flag) and bits 5:0 (source ID) of the write data. Read-back is therefore the write data ANDed with 0x8000003F, and bits 30:6 read as zero.
- R3: Slot n for n in 0..31 sits at byte offset 0x1C+4n. Slot n for n in 32..39 sits at 0xB0+4(n-32). Reads of any offset that is neither a slot nor the status word return 0.
- R4: A slot is considered only when its valid flag is set and its source ID is below 40. Invalid slots and slots naming IDs 40..63 never produce a winner.
- R5: A source is an IRQ candidate when its act_i bit is 1 and its fiq_sel_i bit is 0. It is an FIQ candidate when both bits are 1.
- R6: Within each class, the lowest-numbered eligible slot whose source is a candidate wins. When two slots name the same source, the lower-numbered slot decides the result.
- R7: Status layout: bit 31 set means an IRQ winner exists and bits 21:16 hold its ID. Bit 15 set means an FIQ winner exists and bits 5:0 hold its ID. A half with no winner reads valid 0 and ID 0x3F. All other bits are 0.
- R8: The status word reflects the inputs and slot contents present at the previous rising clock edge. Reading offset 0x18 returns the same value as status_o.
- R9: Writes to the status offset or to any non-slot offset change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 40 | Per-source pending-and-enabled flags |
| fiq_sel_i | input | 40 | Per-source steering: 1 = FIQ, 0 = IRQ |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Byte offset for register read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational on addr_i) |
| status_o | output | 32 | Packed IRQ/FIQ winner status word |

## Verification
The bench targets the cases where priority order matters. These are duplicate slots naming one source, a low slot whose source is steered to the other class, and slots carrying IDs 40..63 or a clear valid flag. A resolver that scanned from the top of the table or let the last match win would report the wrong ID when two candidates compete. One that skipped the ID range check would index past the source vector and report a phantom winner. The bench also writes the status offset and unmapped offsets, then reads all 40 slots back. A decoder that aliased those offsets onto a slot, or stored unmasked bits, would show up there. The split between the two address banks is covered by writes to slots 31 and 32.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  localparam int NUM_SLOTS = 40;
  localparam int NUM_SRC   = 40;
  localparam int ID_W      = 6;
  localparam int DW        = 32;
  localparam int AW        = 8;
  localparam int IDX_W     = $clog2(NUM_SLOTS);
  localparam int LO_SLOTS  = 32;
  localparam int LO_BASE   = 'h1C;
  localparam int HI_BASE   = 'hB0;
  localparam int STAT_OFS  = 'h18;
  localparam int VLD_BIT   = 31;
  localparam logic [ID_W-1:0] NO_ID = '1;

  typedef struct packed {
    logic            vld;
    logic [ID_W-1:0] id;
  } slot_t;

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } win_t;

  function automatic logic [AW-1:0] slot_ofs(input int s);
    if (s < LO_SLOTS) return AW'(LO_BASE + 4 * s);
    return AW'(HI_BASE + 4 * (s - LO_SLOTS));
  endfunction

  function automatic logic [DW-1:0] slot_word(input slot_t x);
    logic [DW-1:0] w;
    w = '0;
    w[VLD_BIT]    = x.vld;
    w[ID_W-1:0]   = x.id;
    return w;
  endfunction
endpackage

// File: rtl/prio_slot_file.sv
module prio_slot_file
  import prio_res_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  slot_t         wslot_i,
  output slot_t         slots_o [NUM_SLOTS],
  output logic          hit_o,
  output logic [DW-1:0] rdata_o
);
  logic [NUM_SLOTS-1:0] hit;
  slot_t                slot_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign hit[s] = (addr_i == slot_ofs(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                slot_q[s] <= '0;
      else if (wr_en_i && hit[s]) slot_q[s] <= wslot_i;
    end

    assign slots_o[s] = slot_q[s];
  end

  assign hit_o = |hit;

  // offsets are distinct, so at most one hit is set
  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (hit[s]) rdata_o = slot_word(slot_q[s]);
  end
endmodule

// File: rtl/prio_first_hit.sv
module prio_first_hit #(
  parameter int N   = 40,
  parameter int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // downward scan: the last assignment is the lowest index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_res_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] act_i,
  input  logic [NUM_SRC-1:0] fiq_sel_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [DW-1:0]      status_o
);
  localparam int NCLS = 2;  // 0 = IRQ, 1 = FIQ

  slot_t                slots [NUM_SLOTS];
  slot_t                wslot;
  logic                 slot_hit;
  logic [DW-1:0]        slot_rdata;
  logic [NUM_SLOTS-1:0] elig;
  logic [NUM_SLOTS-1:0] cand [NCLS];
  win_t                 win  [NCLS];
  logic [DW-1:0]        stat_d, stat_q;
  logic                 unused_wdata;

  assign wslot        = '{vld: wdata_i[VLD_BIT], id: wdata_i[ID_W-1:0]};
  assign unused_wdata = ^wdata_i[VLD_BIT-1:ID_W];

  prio_slot_file i_slots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wslot_i (wslot),
    .slots_o (slots),
    .hit_o   (slot_hit),
    .rdata_o (slot_rdata)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_elig
    assign elig[s]    = slots[s].vld && (int'(slots[s].id) < NUM_SRC);
    assign cand[0][s] = elig[s] && act_i[slots[s].id] && !fiq_sel_i[slots[s].id];
    assign cand[1][s] = elig[s] && act_i[slots[s].id] &&  fiq_sel_i[slots[s].id];
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic             found;
    logic [IDX_W-1:0] idx;

    prio_first_hit #(.N(NUM_SLOTS), .IW(IDX_W)) i_find (
      .req_i   (cand[c]),
      .found_o (found),
      .idx_o   (idx)
    );

    assign win[c].found = found;
    assign win[c].id    = found ? slots[idx].id : NO_ID;
  end

  prio_status_pack i_pack (
    .irq_i  (win[0]),
    .fiq_i  (win[1]),
    .stat_o (stat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= {16'h0000, 1'b0, 9'h0, NO_ID} | ({16'h0000, 1'b0, 9'h0, NO_ID} << 16);
    else         stat_q <= stat_d;
  end

  assign status_o = stat_q;

  always_comb begin
    if (addr_i == AW'(STAT_OFS)) rdata_o = stat_q;
    else if (slot_hit)           rdata_o = slot_rdata;
    else                         rdata_o = '0;
  end
endmodule

// File: rtl/prio_status_pack.sv
module prio_status_pack
  import prio_res_pkg::*;
(
  input  win_t          irq_i,
  input  win_t          fiq_i,
  output logic [DW-1:0] stat_o
);
  localparam int HALF = DW / 2;
  localparam int PADW = HALF - 1 - ID_W;

  assign stat_o = {irq_i.found, {PADW{1'b0}}, irq_i.id,
                   fiq_i.found, {PADW{1'b0}}, fiq_i.id};
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
  import prio_res_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] act_i,
  input logic [NUM_SRC-1:0] fiq_sel_i,
  input logic [AW-1:0]      addr_i,
  input logic [DW-1:0]      rdata_o,
  input logic [DW-1:0]      status_o
);
  logic [NUM_SRC-1:0] act_d, fiq_d;
  logic [ID_W-1:0]    irq_id, fiq_id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_d <= '0;
      fiq_d <= '0;
    end else begin
      act_d <= act_i;
      fiq_d <= fiq_sel_i;
    end
  end

  assign irq_id = status_o[21:16];
  assign fiq_id = status_o[5:0];

  assert_irq_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[31] |-> irq_id == NO_ID);
  assert_fiq_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[15] |-> fiq_id == NO_ID);
  assert_pad_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[30:22] == '0 && status_o[14:6] == '0);
  assert_irq_cand_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[31] |-> (int'(irq_id) < NUM_SRC) && act_d[irq_id] && !fiq_d[irq_id]);
  assert_fiq_cand_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15] |-> (int'(fiq_id) < NUM_SRC) && act_d[fiq_id] && fiq_d[fiq_id]);
  assert_stat_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == AW'(STAT_OFS) |-> rdata_o == status_o);
  assert_slot_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i != AW'(STAT_OFS) |-> rdata_o[30:6] == '0);
endmodule

bind prio_resolver prio_resolver_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .act_i     (act_i),
  .fiq_sel_i (fiq_sel_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .status_o  (status_o)
);

// File: tb/test_prio_resolver.sv
module test_prio_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] act = '0, fsel = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'hFF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, status;

  int          n_chk = 0, n_bad = 0;
  logic [31:0] m_slot [40];
  logic [31:0] exp_stat = 32'h003F003F;

  always #2 clk = ~clk;

  prio_resolver i_prio_resolver (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act), .fiq_sel_i(fsel),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .status_o(status)
  );

  function automatic int addr_to_slot(input logic [7:0] a);
    int v = int'(a);
    if (v % 4 != 0) return -1;
    if (v >= 'h1C && v <= 'h98) return (v - 'h1C) / 4;
    if (v >= 'hB0 && v <= 'hCC) return 32 + (v - 'hB0) / 4;
    return -1;
  endfunction

  function automatic logic [7:0] slot_to_addr(input int s);
    return (s < 32) ? 8'(28 + 4 * s) : 8'(176 + 4 * (s - 32));
  endfunction

  function automatic logic [31:0] model_status();
    int irq = -1, fiq = -1;
    for (int s = 0; s < 40; s++) begin
      int id = int'(m_slot[s][5:0]);
      if (m_slot[s][31] && id < 40 && act[id]) begin
        if (!fsel[id] && irq < 0) irq = id;
        if ( fsel[id] && fiq < 0) fiq = id;
      end
    end
    return {(irq >= 0), 9'b0, (irq >= 0) ? 6'(irq) : 6'h3F,
            (fiq >= 0), 9'b0, (fiq >= 0) ? 6'(fiq) : 6'h3F};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 40; s++) m_slot[s] = '0;
      exp_stat = 32'h003F003F;
    end else begin
      int k;
      exp_stat = model_status();
      k = addr_to_slot(addr);
      if (wr_en && k >= 0) m_slot[k] = wdata & 32'h8000003F;
    end
  end

  task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // per-cycle status compare (R5 R6 R7 R8)
  always @(negedge clk) if (rst_n) check("R8 status", status, exp_stat);

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'hFF;
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    int k;
    logic [31:0] e;
    @(negedge clk);
    addr = a;
    #1;
    k = addr_to_slot(a);
    e = (a == 8'h18) ? exp_stat : (k >= 0) ? m_slot[k] : 32'h0;
    check(req, rdata, e);
    addr = 8'hFF;
  endtask

  task automatic drive(input logic [39:0] a, input logic [39:0] f);
    @(negedge clk);
    act = a; fsel = f;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #9;
    check("R1 reset status", status, 32'h003F003F);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 40; s++) begin
      rd("R1 slot reset", slot_to_addr(s));
      check("R1 slot zero", rdata, 32'h0);
    end

    // R2 masking, R3 bank boundaries
    wr(8'h1C, 32'hFFFFFFFF);
    rd("R2 mask", 8'h1C);
    check("R2 masked value", rdata, 32'h8000003F);
    wr(8'h98, 32'h80000007);
    wr(8'hB0, 32'h80000021);
    rd("R3 slot31", 8'h98);
    rd("R3 slot32", 8'hB0);
    rd("R3 unmapped", 8'h9C);
    rd("R3 unmapped", 8'h1D);

    // R4: slot0 id 63 valid but out of range; slot1 id 40 valid; slot2 invalid id 3
    wr(8'h1C, 32'h8000003F);
    wr(8'h20, 32'h80000028);
    wr(8'h24, 32'h00000003);
    drive(40'hFF_FFFF_FFFF, '0);
    // slot31 (id 7) now wins IRQ over slot32 (id 33): R6
    check("R4 R6 irq winner", status, {1'b1, 9'b0, 6'd7, 1'b0, 9'b0, 6'h3F});
    drive(40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF);
    check("R5 fiq winner", status, {1'b0, 9'b0, 6'h3F, 1'b1, 9'b0, 6'd7});

    // R6 duplicates: slot5 and slot6 both name source 10 with differing class context
    wr(8'h30, 32'h8000000A);
    wr(8'h34, 32'h8000000A);
    wr(8'h38, 32'h80000002);
    drive(40'h0000000404, 40'h0000000004);
    check("R6 dup/split", status, {1'b1, 9'b0, 6'd10, 1'b1, 9'b0, 6'd2});
    rd("R8 status read", 8'h18);

    // R9: writes to status and unmapped offsets change nothing
    wr(8'h18, 32'h8000000B);
    wr(8'h00, 32'h8000000B);
    wr(8'hA0, 32'h8000000B);
    wr(8'hD0, 32'h8000000B);
    wr(8'h32, 32'h8000000B);
    for (int s = 0; s < 40; s++) rd("R9 no alias", slot_to_addr(s));
    drive('0, '0);
    check("R7 idle", status, 32'h003F003F);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      act  = {$urandom, $urandom} & {$urandom, $urandom};
      fsel = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) begin
        int s = $urandom_range(0, 39);
        wr_en = 1'b1;
        addr  = ($urandom_range(0, 9) == 0) ? 8'($urandom) : slot_to_addr(s);
        wdata = {$urandom_range(0, 5) != 0, 25'($urandom), 6'($urandom_range(0, 47))};
      end else begin
        wr_en = 1'b0;
        addr  = 8'hFF;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    for (int s = 0; s < 40; s++) rd("R2 R3 final readback", slot_to_addr(s));
    rd("R8 final status read", 8'h18);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule